// File: doc/BRIEF.md
# MI Coherence Line Controller

This block controls one line of a private cache under a protocol with only two stable states, Modified and Invalid, plus three transient states that cover an outstanding fetch, an outstanding store miss and an outstanding writeback. It watches the heads of three queues: processor requests (load, instruction fetch, store, atomic), forwarded requests from the directory (exclusive-ownership request, invalidate) and responses from the directory (fill data, writeback acknowledge, writeback refusal). In each cycle it picks at most one of those heads, decodes it into a protocol event and either consumes it (pop) or leaves it in place (stall).

Acting on an event, the controller can send a GET or PUT request towards the directory, send a data response for a forwarded ownership request, complete a processor request with its data, and update the access permission that gates the line. A single transaction buffer entry holds either the pending store data of a store miss or the line data of a writeback in flight. The tag array and victim choice are reduced to the line's own tag register: a processor request to another line while this line is Modified is treated as a replacement of this line.

Top module: `mi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid, `perm_rw` is 0 and no queue is popped or request sent while no input is valid; a reset while Modified discards the line, so the next access misses.
- R2: In Invalid, a processor request of kind 00 (load), 01 (fetch), 10 (store) or 11 (atomic) is popped and sends a GET (`req_type` 0) carrying the line address, `preq_addr >> OFFS_W`.
- R3: `perm_rw` is 1 exactly in the cycles where the line is Modified, and 0 in every other state.
- R4: A response of type 00 (data) while a fetch or store miss is pending is popped, completes the request (`preq_done` with `preq_rdata` equal to the response data for a load or fetch, or the store data for a store or atomic) and makes the line Modified with that value.
- R5: In Modified, loads and fetches to the line return its data and a store or atomic overwrites it, each completing and popping in the same cycle; addresses are matched on the line address, so the low `OFFS_W` bits are ignored.
- R6: While a fetch or store miss is pending, forwarded requests of type 00 or 01 and all processor requests are left unpopped.
- R7: A processor request to a different line while Modified is not popped; it sends a PUT (`req_type` 1) with the old line address and data and moves the line to the writeback state, where the request keeps stalling.
- R8: A forwarded invalidate (type 01) in Modified is popped and sends a PUT with the line data, moving to the writeback state; in Invalid or in the writeback state it is popped with no other effect.
- R9: A forwarded ownership request (type 00) in Modified sends a data response with the line data and leaves the line Invalid; in the writeback state it sends the held writeback data and stays; in Invalid it is popped and dropped.
- R10: In the writeback state a response of type 01 (acknowledge) or 10 (refusal) is popped and the line becomes Invalid, with no data resent.
- R11: Responses take priority over forwarded requests, which take priority over processor requests; at most one queue is popped per cycle.
- R12: A forwarded type 10 or 11, a response type 11, or a response the current state does not expect raises `proto_err`, is popped, and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preq_valid | input | 1 | Processor request present at queue head |
| preq_kind | input | 2 | 00 load, 01 fetch, 10 store, 11 atomic |
| preq_addr | input | ADDR_W | Byte address of the request |
| preq_wdata | input | DATA_W | Store or atomic data (whole line word) |
| preq_pop | output | 1 | Processor request consumed this cycle |
| preq_done | output | 1 | Processor request completes this cycle |
| preq_rdata | output | DATA_W | Line value returned with completion |
| fwd_valid | input | 1 | Forwarded request present |
| fwd_type | input | 2 | 00 ownership request, 01 invalidate, others illegal |
| fwd_pop | output | 1 | Forwarded request consumed |
| resp_valid | input | 1 | Response present |
| resp_type | input | 2 | 00 data, 01 writeback ack, 10 writeback refusal, 11 illegal |
| resp_data | input | DATA_W | Fill data |
| resp_pop | output | 1 | Response consumed |
| req_valid | output | 1 | Request to the directory this cycle |
| req_type | output | 1 | 0 GET, 1 PUT |
| req_line | output | ADDR_W-OFFS_W | Line address of the request |
| req_data | output | DATA_W | Writeback data carried by a PUT |
| dresp_valid | output | 1 | Data response for a forwarded ownership request |
| dresp_data | output | DATA_W | Data of that response |
| perm_rw | output | 1 | Line readable and writable |
| proto_err | output | 1 | Illegal or unexpected message consumed |

## Verification
The bench builds the controller with a 12-bit address, 3 offset bits and a 16-bit data word, so line addresses are 9 bits and two byte addresses inside one line differ only in ignored bits. It selects the registered permission variant, which brings the check that the permission flop and the state register never disagree into play. The narrow widths keep the vector table readable while still covering hits, misses, replacement to a second line, and every stall and drop case.

// File: rtl/mi_pkg.sv
package mi_pkg;

   typedef enum logic [2:0] {
      ST_I  = 3'd0,
      ST_IS = 3'd1,
      ST_IM = 3'd2,
      ST_M  = 3'd3,
      ST_MI = 3'd4
   } mi_state_e;

   typedef enum logic [3:0] {
      EV_NONE,
      EV_LOAD,
      EV_IFETCH,
      EV_STORE,
      EV_DATA,
      EV_FWD_GETX,
      EV_INV,
      EV_REPL,
      EV_WB_ACK,
      EV_WB_NACK,
      EV_BAD_FWD,
      EV_BAD_RESP
   } mi_event_e;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_RESP,
      SRC_FWD,
      SRC_PROC
   } mi_src_e;

   localparam logic [1:0] PK_LOAD    = 2'b00;
   localparam logic [1:0] PK_IFETCH  = 2'b01;
   localparam logic [1:0] RT_DATA    = 2'b00;
   localparam logic [1:0] RT_WB_ACK  = 2'b01;
   localparam logic [1:0] RT_WB_NACK = 2'b10;
   localparam logic [1:0] FT_GETX    = 2'b00;
   localparam logic [1:0] FT_INV     = 2'b01;
   localparam logic       REQ_GET    = 1'b0;
   localparam logic       REQ_PUT    = 1'b1;

endpackage

// File: rtl/mi_evt_dec.sv
module mi_evt_dec
   import mi_pkg::*;
#(
   parameter int LINE_W = 12
) (
   input  logic              resp_valid,
   input  logic [1:0]        resp_type,
   input  logic              fwd_valid,
   input  logic [1:0]        fwd_type,
   input  logic              preq_valid,
   input  logic [1:0]        preq_kind,
   input  logic [LINE_W-1:0] preq_line,
   input  logic              line_busy,
   input  logic [LINE_W-1:0] tag_line,
   output mi_event_e         evt,
   output mi_src_e           src
);

   always_comb begin
      evt = EV_NONE;
      src = SRC_NONE;
      if (resp_valid) begin
         src = SRC_RESP;
         case (resp_type)
            RT_DATA:    evt = EV_DATA;
            RT_WB_ACK:  evt = EV_WB_ACK;
            RT_WB_NACK: evt = EV_WB_NACK;
            default:    evt = EV_BAD_RESP;
         endcase
      end else if (fwd_valid) begin
         src = SRC_FWD;
         case (fwd_type)
            FT_GETX: evt = EV_FWD_GETX;
            FT_INV:  evt = EV_INV;
            default: evt = EV_BAD_FWD;
         endcase
      end else if (preq_valid) begin
         src = SRC_PROC;
         if (line_busy && (preq_line != tag_line)) begin
            evt = EV_REPL;
         end else begin
            case (preq_kind)
               PK_LOAD:   evt = EV_LOAD;
               PK_IFETCH: evt = EV_IFETCH;
               default:   evt = EV_STORE;
            endcase
         end
      end
   end

endmodule

// File: rtl/mi_tbe.sv
module mi_tbe #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              free,
   input  logic              alloc_store,
   input  logic [DATA_W-1:0] alloc_data,
   output logic              valid,
   output logic              is_store,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         is_store <= 1'b0;
         data     <= '0;
      end else if (alloc) begin
         valid    <= 1'b1;
         is_store <= alloc_store;
         data     <= alloc_data;
      end else if (free) begin
         valid    <= 1'b0;
      end
   end

   // R2
   tbe_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> !valid);

   // R10
   tbe_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free |-> valid);

endmodule

// File: rtl/mi_line_fsm.sv
module mi_line_fsm
   import mi_pkg::*;
#(
   parameter int LINE_W    = 12,
   parameter int DATA_W    = 32,
   parameter bit PERM_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mi_event_e         evt,
   input  logic [LINE_W-1:0] preq_line,
   input  logic [DATA_W-1:0] preq_wdata,
   input  logic [DATA_W-1:0] resp_data,
   input  logic              tbe_is_store,
   input  logic [DATA_W-1:0] tbe_data,
   output mi_state_e         st,
   output logic [LINE_W-1:0] tag_line,
   output logic              accept,
   output logic              tbe_alloc,
   output logic              tbe_free,
   output logic              tbe_alloc_store,
   output logic [DATA_W-1:0] tbe_alloc_data,
   output logic              req_valid,
   output logic              req_type,
   output logic [LINE_W-1:0] req_line,
   output logic [DATA_W-1:0] req_data,
   output logic              dresp_valid,
   output logic [DATA_W-1:0] dresp_data,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              perm_rw,
   output logic              proto_err
);

   mi_state_e         nxt;
   logic [LINE_W-1:0] tag_d;
   logic [DATA_W-1:0] line_q, line_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_I;
         tag_line <= '0;
         line_q   <= '0;
      end else begin
         st       <= nxt;
         tag_line <= tag_d;
         line_q   <= line_d;
      end
   end

   always_comb begin
      nxt             = st;
      tag_d           = tag_line;
      line_d          = line_q;
      accept          = 1'b0;
      tbe_alloc       = 1'b0;
      tbe_free        = 1'b0;
      tbe_alloc_store = 1'b0;
      tbe_alloc_data  = '0;
      req_valid       = 1'b0;
      req_type        = REQ_GET;
      req_line        = tag_line;
      req_data        = line_q;
      dresp_valid     = 1'b0;
      dresp_data      = line_q;
      done            = 1'b0;
      rdata           = line_q;
      proto_err       = 1'b0;
      unique case (st)
         ST_I: begin
            if (evt inside {EV_LOAD, EV_IFETCH, EV_STORE}) begin
               accept          = 1'b1;
               tbe_alloc       = 1'b1;
               tbe_alloc_store = (evt == EV_STORE);
               tbe_alloc_data  = preq_wdata;
               req_valid       = 1'b1;
               req_type        = REQ_GET;
               req_line        = preq_line;
               tag_d           = preq_line;
               nxt             = (evt == EV_STORE) ? ST_IM : ST_IS;
            end else if (evt inside {EV_INV, EV_FWD_GETX}) begin
               accept = 1'b1;
            end else if (evt != EV_NONE) begin
               accept    = 1'b1;
               proto_err = 1'b1;
            end
         end
         ST_IS, ST_IM: begin
            if (evt == EV_DATA) begin
               accept   = 1'b1;
               tbe_free = 1'b1;
               done     = 1'b1;
               line_d   = tbe_is_store ? tbe_data : resp_data;
               rdata    = line_d;
               nxt      = ST_M;
            end else if (evt inside {EV_WB_ACK, EV_WB_NACK, EV_BAD_FWD, EV_BAD_RESP}) begin
               accept    = 1'b1;
               proto_err = 1'b1;
            end
         end
         ST_M: begin
            if (evt inside {EV_LOAD, EV_IFETCH}) begin
               accept = 1'b1;
               done   = 1'b1;
            end else if (evt == EV_STORE) begin
               accept = 1'b1;
               done   = 1'b1;
               line_d = preq_wdata;
               rdata  = preq_wdata;
            end else if (evt == EV_FWD_GETX) begin
               accept      = 1'b1;
               dresp_valid = 1'b1;
               nxt         = ST_I;
            end else if (evt inside {EV_INV, EV_REPL}) begin
               accept         = (evt == EV_INV);
               tbe_alloc      = 1'b1;
               tbe_alloc_data = line_q;
               req_valid      = 1'b1;
               req_type       = REQ_PUT;
               nxt            = ST_MI;
            end else if (evt != EV_NONE) begin
               accept    = 1'b1;
               proto_err = 1'b1;
            end
         end
         ST_MI: begin
            if (evt inside {EV_WB_ACK, EV_WB_NACK}) begin
               accept   = 1'b1;
               tbe_free = 1'b1;
               nxt      = ST_I;
            end else if (evt == EV_INV) begin
               accept = 1'b1;
            end else if (evt == EV_FWD_GETX) begin
               accept      = 1'b1;
               dresp_valid = 1'b1;
               dresp_data  = tbe_data;
            end else if (evt inside {EV_DATA, EV_BAD_FWD, EV_BAD_RESP}) begin
               accept    = 1'b1;
               proto_err = 1'b1;
            end
         end
         default: begin
            nxt = ST_I;
         end
      endcase
   end

   generate
      if (PERM_FLOP) begin : g_perm_flop
         logic perm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) perm_q <= 1'b0;
            else        perm_q <= (nxt == ST_M);
         end
         assign perm_rw = perm_q;

         // R3
         perm_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
            perm_rw == (st == ST_M));
      end else begin : g_perm_dec
         assign perm_rw = (st == ST_M);
      end
   endgenerate

   // R7
   put_to_mi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_type == REQ_PUT) |=> (st == ST_MI));

   // R4
   fill_to_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == EV_DATA && (st == ST_IS || st == ST_IM)) |=> (st == ST_M));

   // R12
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> (st == $past(st)));

endmodule

// File: rtl/mi_line_ctrl.sv
module mi_line_ctrl
   import mi_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int OFFS_W    = 4,
   parameter int DATA_W    = 32,
   parameter bit PERM_FLOP = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     preq_valid,
   input  logic [1:0]               preq_kind,
   input  logic [ADDR_W-1:0]        preq_addr,
   input  logic [DATA_W-1:0]        preq_wdata,
   output logic                     preq_pop,
   output logic                     preq_done,
   output logic [DATA_W-1:0]        preq_rdata,
   input  logic                     fwd_valid,
   input  logic [1:0]               fwd_type,
   output logic                     fwd_pop,
   input  logic                     resp_valid,
   input  logic [1:0]               resp_type,
   input  logic [DATA_W-1:0]        resp_data,
   output logic                     resp_pop,
   output logic                     req_valid,
   output logic                     req_type,
   output logic [ADDR_W-OFFS_W-1:0] req_line,
   output logic [DATA_W-1:0]        req_data,
   output logic                     dresp_valid,
   output logic [DATA_W-1:0]        dresp_data,
   output logic                     perm_rw,
   output logic                     proto_err
);

   localparam int LINE_W = ADDR_W - OFFS_W;

   generate
      if (OFFS_W < 1 || OFFS_W >= ADDR_W) begin : g_bad_offs
         $error("mi_line_ctrl: OFFS_W must lie in 1..ADDR_W-1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mi_line_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic [LINE_W-1:0] preq_line, tag_line;
   logic [OFFS_W-1:0] unused_offs;
   mi_event_e         evt;
   mi_src_e           src;
   mi_state_e         st;
   logic              accept;
   logic              tbe_alloc, tbe_free, tbe_alloc_store;
   logic [DATA_W-1:0] tbe_alloc_data, tbe_data;
   logic              tbe_valid, tbe_is_store;

   assign preq_line   = preq_addr[ADDR_W-1:OFFS_W];
   assign unused_offs = preq_addr[OFFS_W-1:0];

   mi_evt_dec #(.LINE_W(LINE_W)) dec_i (
      .resp_valid (resp_valid),
      .resp_type  (resp_type),
      .fwd_valid  (fwd_valid),
      .fwd_type   (fwd_type),
      .preq_valid (preq_valid),
      .preq_kind  (preq_kind),
      .preq_line  (preq_line),
      .line_busy  (st != ST_I),
      .tag_line   (tag_line),
      .evt        (evt),
      .src        (src)
   );

   mi_line_fsm #(
      .LINE_W    (LINE_W),
      .DATA_W    (DATA_W),
      .PERM_FLOP (PERM_FLOP)
   ) fsm_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .evt             (evt),
      .preq_line       (preq_line),
      .preq_wdata      (preq_wdata),
      .resp_data       (resp_data),
      .tbe_is_store    (tbe_is_store),
      .tbe_data        (tbe_data),
      .st              (st),
      .tag_line        (tag_line),
      .accept          (accept),
      .tbe_alloc       (tbe_alloc),
      .tbe_free        (tbe_free),
      .tbe_alloc_store (tbe_alloc_store),
      .tbe_alloc_data  (tbe_alloc_data),
      .req_valid       (req_valid),
      .req_type        (req_type),
      .req_line        (req_line),
      .req_data        (req_data),
      .dresp_valid     (dresp_valid),
      .dresp_data      (dresp_data),
      .done            (preq_done),
      .rdata           (preq_rdata),
      .perm_rw         (perm_rw),
      .proto_err       (proto_err)
   );

   mi_tbe #(.DATA_W(DATA_W)) tbe_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (tbe_alloc),
      .free        (tbe_free),
      .alloc_store (tbe_alloc_store),
      .alloc_data  (tbe_alloc_data),
      .valid       (tbe_valid),
      .is_store    (tbe_is_store),
      .data        (tbe_data)
   );

   assign resp_pop = accept && (src == SRC_RESP);
   assign fwd_pop  = accept && (src == SRC_FWD);
   assign preq_pop = accept && (src == SRC_PROC);

   // R11
   one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({resp_pop, fwd_pop, preq_pop}) <= 1);

   // R11
   resp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (!fwd_pop && !preq_pop));

   // R6
   pend_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IS || st == ST_IM) && !resp_valid && fwd_valid && !fwd_type[1])
         |-> (!fwd_pop && !preq_pop));

   // R10
   tbe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbe_valid == (st == ST_IS || st == ST_IM || st == ST_MI));

   // R4
   tbe_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbe_valid && st != ST_MI) |-> (tbe_is_store == (st == ST_IM)));

endmodule

// File: tb/mi_line_ctrl_tb.sv
module mi_line_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 12;
   localparam int OFFS_W = 3;
   localparam int DATA_W = 16;
   localparam int LINE_W = ADDR_W - OFFS_W;
   localparam int NVEC   = 26;

   typedef struct packed {
      logic        pv;
      logic [1:0]  pk;
      logic [11:0] pa;
      logic [15:0] pw;
      logic        fv;
      logic [1:0]  ft;
      logic        rv;
      logic [1:0]  rt;
      logic [15:0] rd;
      logic [2:0]  e_pop;   // {preq, fwd, resp}
      logic        e_rqv;
      logic        e_rqt;
      logic [8:0]  e_rql;
      logic [15:0] e_rqd;
      logic        e_dv;
      logic [15:0] e_dd;
      logic        e_done;
      logic [15:0] e_rdata;
      logic        e_perm;
      logic        e_err;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      // 0 R1 idle after reset
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b000, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 1 R2 load miss in I
      '{1'b1,2'd0,12'h0A8,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b1,1'b0,9'h015,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 2 R6 invalidate stalls while pending
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd1, 1'b0,2'd0,16'h0000, 3'b000, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 3 R4 R11 fill wins over fwd and proc
      '{1'b1,2'd0,12'h0A8,16'h0000, 1'b1,2'd1, 1'b1,2'd0,16'h1234, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h1234, 1'b0,1'b0},
      // 4 R5 R3 load hit at other offset in same line
      '{1'b1,2'd0,12'h0AD,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h1234, 1'b1,1'b0},
      // 5 R5 store hit
      '{1'b1,2'd2,12'h0A8,16'hBEEF, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'hBEEF, 1'b1,1'b0},
      // 6 R5 fetch hit sees stored value
      '{1'b1,2'd1,12'h0A8,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'hBEEF, 1'b1,1'b0},
      // 7 R7 replacement: PUT old line, no pop
      '{1'b1,2'd0,12'h1F0,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b000, 1'b1,1'b1,9'h015,16'hBEEF, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
      // 8 R7 R3 request stalls in writeback
      '{1'b1,2'd0,12'h1F0,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b000, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 9 R8 R11 invalidate dropped in writeback, ahead of proc
      '{1'b1,2'd0,12'h1F0,16'h0000, 1'b1,2'd1, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 10 R9 ownership request in writeback sends held data
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd0, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b1,16'hBEEF, 1'b0,16'h0000, 1'b0,1'b0},
      // 11 R10 writeback ack
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b1,2'd1,16'h0000, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 12 R2 atomic miss to other line
      '{1'b1,2'd3,12'h1F0,16'h5A5A, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b1,1'b0,9'h03E,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 13 R6 ownership request stalls while store pending
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd0, 1'b0,2'd0,16'h0000, 3'b000, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 14 R4 fill for store keeps store data
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b1,2'd0,16'h1111, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h5A5A, 1'b0,1'b0},
      // 15 R5 load hit
      '{1'b1,2'd0,12'h1F2,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h5A5A, 1'b1,1'b0},
      // 16 R8 invalidate in M becomes writeback
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd1, 1'b0,2'd0,16'h0000, 3'b010, 1'b1,1'b1,9'h03E,16'h5A5A, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
      // 17 R10 writeback refusal
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b1,2'd2,16'h0000, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 18 R8 invalidate in I dropped
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd1, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 19 R12 illegal forwarded type
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd2, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b1},
      // 20 R12 unexpected data in I
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b1,2'd0,16'h9999, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b1},
      // 21 R9 ownership request in I dropped
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd0, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 22 R2 load miss again
      '{1'b1,2'd0,12'h0A8,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b100, 1'b1,1'b0,9'h015,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
      // 23 R4 fill
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b1,2'd0,16'h7777, 3'b001, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b1,16'h7777, 1'b0,1'b0},
      // 24 R9 ownership request in M sends data
      '{1'b0,2'd0,12'h000,16'h0000, 1'b1,2'd0, 1'b0,2'd0,16'h0000, 3'b010, 1'b0,1'b0,9'h000,16'h0000, 1'b1,16'h7777, 1'b0,16'h0000, 1'b1,1'b0},
      // 25 R3 back in I
      '{1'b0,2'd0,12'h000,16'h0000, 1'b0,2'd0, 1'b0,2'd0,16'h0000, 3'b000, 1'b0,1'b0,9'h000,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              preq_valid = 1'b0;
   logic [1:0]        preq_kind = '0;
   logic [ADDR_W-1:0] preq_addr = '0;
   logic [DATA_W-1:0] preq_wdata = '0;
   logic              preq_pop, preq_done;
   logic [DATA_W-1:0] preq_rdata;
   logic              fwd_valid = 1'b0;
   logic [1:0]        fwd_type = '0;
   logic              fwd_pop;
   logic              resp_valid = 1'b0;
   logic [1:0]        resp_type = '0;
   logic [DATA_W-1:0] resp_data = '0;
   logic              resp_pop;
   logic              req_valid, req_type;
   logic [LINE_W-1:0] req_line;
   logic [DATA_W-1:0] req_data;
   logic              dresp_valid;
   logic [DATA_W-1:0] dresp_data;
   logic              perm_rw, proto_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mi_line_ctrl #(
      .ADDR_W    (ADDR_W),
      .OFFS_W    (OFFS_W),
      .DATA_W    (DATA_W),
      .PERM_FLOP (1'b1)
   ) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .preq_valid  (preq_valid),
      .preq_kind   (preq_kind),
      .preq_addr   (preq_addr),
      .preq_wdata  (preq_wdata),
      .preq_pop    (preq_pop),
      .preq_done   (preq_done),
      .preq_rdata  (preq_rdata),
      .fwd_valid   (fwd_valid),
      .fwd_type    (fwd_type),
      .fwd_pop     (fwd_pop),
      .resp_valid  (resp_valid),
      .resp_type   (resp_type),
      .resp_data   (resp_data),
      .resp_pop    (resp_pop),
      .req_valid   (req_valid),
      .req_type    (req_type),
      .req_line    (req_line),
      .req_data    (req_data),
      .dresp_valid (dresp_valid),
      .dresp_data  (dresp_data),
      .perm_rw     (perm_rw),
      .proto_err   (proto_err)
   );

   task automatic chk(input string tag, input int vi, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s step=%0d actual=%h expected=%h", tag, vi, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic drive(input logic pv, input logic [1:0] pk, input logic [11:0] pa,
                        input logic [15:0] pw, input logic fv, input logic [1:0] ft,
                        input logic rv, input logic [1:0] rt, input logic [15:0] rd);
      @(posedge clk);
      #1;
      preq_valid = pv; preq_kind = pk; preq_addr = pa; preq_wdata = pw;
      fwd_valid  = fv; fwd_type  = ft;
      resp_valid = rv; resp_type = rt; resp_data = rd;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         v = VECS[i];
         drive(v.pv, v.pk, v.pa, v.pw, v.fv, v.ft, v.rv, v.rt, v.rd);
         chk("R11 pops", i, {29'd0, preq_pop, fwd_pop, resp_pop}, {29'd0, v.e_pop});
         chk("R3 perm", i, {31'd0, perm_rw}, {31'd0, v.e_perm});
         chk("R12 err", i, {31'd0, proto_err}, {31'd0, v.e_err});
         chk("R2 R7 req_valid", i, {31'd0, req_valid}, {31'd0, v.e_rqv});
         if (v.e_rqv) begin
            chk("R2 R7 req_type", i, {31'd0, req_type}, {31'd0, v.e_rqt});
            chk("R2 R7 req_line", i, {23'd0, req_line}, {23'd0, v.e_rql});
            if (v.e_rqt) chk("R7 R8 put_data", i, {16'd0, req_data}, {16'd0, v.e_rqd});
         end
         chk("R9 dresp_valid", i, {31'd0, dresp_valid}, {31'd0, v.e_dv});
         if (v.e_dv) chk("R9 dresp_data", i, {16'd0, dresp_data}, {16'd0, v.e_dd});
         chk("R4 R5 done", i, {31'd0, preq_done}, {31'd0, v.e_done});
         if (v.e_done) chk("R4 R5 rdata", i, {16'd0, preq_rdata}, {16'd0, v.e_rdata});
      end

      // R4: bring the line to M with 4242
      drive(1'b1, 2'd0, 12'h0A8, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
      drive(1'b0, 2'd0, 12'h0, 16'h0, 1'b0, 2'd0, 1'b1, 2'd0, 16'h4242);
      drive(1'b0, 2'd0, 12'h0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
      chk("R3 perm_after_fill", 100, {31'd0, perm_rw}, 32'd1);

      // R11 R12: all three valid in M, unexpected data response wins and errors
      drive(1'b1, 2'd0, 12'h0A8, 16'h0, 1'b1, 2'd1, 1'b1, 2'd0, 16'h9999);
      chk("R11 three_way_pops", 101, {29'd0, preq_pop, fwd_pop, resp_pop}, 32'b001);
      chk("R12 err_in_M", 101, {31'd0, proto_err}, 32'd1);
      drive(1'b1, 2'd0, 12'h0A8, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
      chk("R12 state_kept_perm", 102, {31'd0, perm_rw}, 32'd1);
      chk("R12 line_kept_rdata", 102, {16'd0, preq_rdata}, 32'h4242);

      // R1: reset while Modified
      @(posedge clk);
      #1;
      preq_valid = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 perm_after_reset", 103, {31'd0, perm_rw}, 32'd0);
      chk("R1 idle_pops", 103, {29'd0, preq_pop, fwd_pop, resp_pop}, 32'd0);
      chk("R1 idle_req", 103, {31'd0, req_valid}, 32'd0);
      drive(1'b1, 2'd0, 12'h0A8, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);
      chk("R1 miss_after_reset", 104, {31'd0, req_valid}, 32'd1);
      chk("R1 miss_no_done", 104, {31'd0, preq_done}, 32'd0);
      drive(1'b0, 2'd0, 12'h0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0);

      report();
   end

endmodule